// File: doc/BRIEF.md
# Selectable-Prescaler Interval Timer

This block produces the periodic interval tick that feeds a watchdog. A free-running prescaler divides the system clock. A 3-bit select field picks one of eight power-of-two taps, from /8 up to /1024. A source bit in the control register can replace the divided clock with the rising edges of a separate, always-running slow oscillator. That oscillator is modelled as a level input from another clock domain and is synchronized before use.

The chosen tick advances an up counter. When the counter wraps, the block emits a single-cycle interval pulse toward the watchdog and sets a sticky interrupt flag. Software reaches the block through one byte-wide control register that supports full-byte writes only. One bit of that register is a clear strobe: it zeroes the counter and the flag.

Top module: `interval_prescale_timer`

## Requirements
- R1: After reset:
  - `rd_data_o` reads 0x17, meaning select field 111, watchdog enable 1, source 0, clear 0, and bits 7:6 at 0.
  - `cnt_o`, `ovf_o` and `irq_o` are 0.
  - `wd_en_o` is 1.
- R2: A write with `wr_en_i` high loads the whole register at the next clock edge:
  - bits 2:0 load the select field;
  - bit 4 loads the watchdog enable;
  - bit 5 loads the source select.
  Bits 7, 6 and 3 always read back as 0.
- R3: When the source bit is 0, select code s gives a division of 2^(3+s), so codes 0 to 7 give /8 to /1024 in ascending order.
  - The prescaler counts every cycle from reset and is never cleared by writes.
  - The counter advances at each edge where the low 3+s prescaler bits are all ones. This is edge number 2^(3+s), then every 2^(3+s) edges after reset.
- R4: When the source bit is 1, the counter advances once per rising edge of `osc_i`, and the divided clock has no effect.
  - The increment lands on the third clock edge counted from the first edge that samples `osc_i` high.
  - A constant `osc_i` leaves the counter unchanged.
- R5: The counter wraps from its maximum to 0. `ovf_o` is high for exactly one cycle, which is the cycle in which `cnt_o` first reads 0 after the wrap.
- R6: `irq_o` goes high together with `ovf_o` and stays high until a clear.
- R7: A write with bit 3 set zeroes `cnt_o` and `irq_o` at that edge.
  - The clear overrides a tick in the same cycle, and no `ovf_o` pulse results.
  - The clear leaves the prescaler running.
- R8: `wd_en_o` follows register bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Slow free-running oscillator level, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write byte |
| rd_data_o | output | 8 | Register read byte |
| cnt_o | output | CNT_W | Interval counter value |
| ovf_o | output | 1 | One-cycle interval pulse on wrap |
| irq_o | output | 1 | Sticky interval interrupt flag |
| wd_en_o | output | 1 | Watchdog enable bit |

## Verification
The bench builds the block with CNT_W=4. Overflow therefore comes every 16 ticks instead of 256. This makes wraps reachable on every tap, including /1024, with a full wrap at /1024 in about 16k cycles. The rest of the parameters keep their defaults: DIV_BASE=3 and a two-stage synchronizer. The register layout and the whole eight-tap divider are therefore exercised exactly as built.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned BIT_CLR = 3;
  localparam int unsigned BIT_WDE = 4;
  localparam int unsigned BIT_SRC = 5;

  typedef struct packed {
    logic             src;
    logic             wd_en;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{src: 1'b0, wd_en: 1'b1, sel: '1};
endpackage

// File: rtl/ipt_ctrl_reg.sv
module ipt_ctrl_reg
  import ipt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o,
  output logic             clr_o,
  output logic [REG_W-1:0] rd_data_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_en_i) begin
      ctrl_q <= '{src:   wr_data_i[BIT_SRC],
                  wd_en: wr_data_i[BIT_WDE],
                  sel:   wr_data_i[SEL_W-1:0]};
    end
  end

  // clear is a strobe, never stored
  assign clr_o  = wr_en_i & wr_data_i[BIT_CLR];
  assign ctrl_o = ctrl_q;

  always_comb begin
    rd_data_o              = '0;
    rd_data_o[SEL_W-1:0]   = ctrl_q.sel;
    rd_data_o[BIT_WDE]     = ctrl_q.wd_en;
    rd_data_o[BIT_SRC]     = ctrl_q.src;
  end

  a_r2_sel_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[SEL_W-1:0] == $past(wr_data_i[SEL_W-1:0])));

  a_r8_wde_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_o.wd_en == $past(wr_data_i[BIT_WDE])));
endmodule

// File: rtl/ipt_prescaler.sv
module ipt_prescaler #(
  parameter int unsigned DIV_BASE = 3,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned N_TAPS = 1 << SEL_W;
  localparam int unsigned PRE_W  = DIV_BASE + N_TAPS - 1;

  logic [PRE_W-1:0]  pre_q;
  logic [N_TAPS-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // tap i fires once per 2^(DIV_BASE+i) cycles
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assign taps[i] = &pre_q[DIV_BASE+i-1:0];
  end

  assign tick_o = taps[sel_i];

  a_r3_tick_sparse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ipt_osc_sync.sv
module ipt_osc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], osc_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick_o = sync_q[STAGES-1] & ~prev_q;

  a_r4_one_tick_per_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ipt_counter.sv
module ipt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             flag_q;
  logic             wrap;

  assign wrap = tick_i & ~clr_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (clr_i) begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (tick_i) cnt_q <= cnt_q + 1'b1;
        if (wrap)   flag_q <= 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign flag_o = flag_q;

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r5_ovf_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cnt_q == '0));

  a_r6_flag_with_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> flag_q);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !flag_q && !ovf_q));
endmodule

// File: rtl/interval_prescale_timer.sv
module interval_prescale_timer
  import ipt_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned DIV_BASE    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             irq_o,
  output logic             wd_en_o
);
  ctrl_t ctrl;
  logic  clr;
  logic  div_tick;
  logic  osc_tick;
  logic  tick;

  ipt_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl),
    .clr_o    (clr),
    .rd_data_o(rd_data_o)
  );

  ipt_prescaler #(.DIV_BASE(DIV_BASE), .SEL_W(SEL_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (ctrl.sel),
    .tick_o(div_tick)
  );

  ipt_osc_sync #(.STAGES(SYNC_STAGES)) u_osc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .osc_i (osc_i),
    .tick_o(osc_tick)
  );

  assign tick = ctrl.src ? osc_tick : div_tick;

  ipt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .clr_i (clr),
    .cnt_o (cnt_o),
    .ovf_o (ovf_o),
    .flag_o(irq_o)
  );

  assign wd_en_o = ctrl.wd_en;

  a_r4_divider_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.src && !osc_tick && !clr) |=> $stable(cnt_o));
endmodule

// File: tb/tb_interval_prescale_timer.sv
module tb_interval_prescale_timer;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          osc_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [7:0]    wr_data_i = '0;
  logic [7:0]    rd_data_o;
  logic [CW-1:0] cnt_o;
  logic          ovf_o, irq_o, wd_en_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  interval_prescale_timer #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .osc_i(osc_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .cnt_o(cnt_o), .ovf_o(ovf_o), .irq_o(irq_o), .wd_en_o(wd_en_o)
  );

  // reference model
  int            m_pre;
  logic [2:0]    m_sel;
  logic          m_wde, m_src, m_s1, m_s2, m_s3, m_ovf, m_flag;
  logic [CW-1:0] m_cnt;
  bit            m_tick, m_clr;

  function automatic bit div_hit(int pre, logic [2:0] sel);
    int mask = (1 << (3 + sel)) - 1;
    return (pre & mask) == mask;
  endfunction

  function automatic logic [7:0] exp_rd();
    return {2'b00, m_src, m_wde, 1'b0, m_sel};
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_sel = 3'b111; m_wde = 1'b1; m_src = 1'b0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ovf = 0; m_flag = 0; m_cnt = '0;
    end else begin
      m_tick = m_src ? (m_s2 && !m_s3) : div_hit(m_pre, m_sel);
      m_clr  = wr_en_i && wr_data_i[3];
      m_pre  = m_pre + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = osc_i;
      if (m_clr) begin
        m_cnt = '0; m_flag = 0; m_ovf = 0;
      end else if (m_tick) begin
        m_ovf = (m_cnt == {CW{1'b1}});
        if (m_ovf) m_flag = 1;
        m_cnt = m_cnt + 1'b1;
      end else begin
        m_ovf = 0;
      end
      if (wr_en_i) begin
        m_sel = wr_data_i[2:0]; m_wde = wr_data_i[4]; m_src = wr_data_i[5];
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cnt_o == m_cnt, m_src ? "R4 count" : "R3 count", int'(cnt_o), int'(m_cnt));
      chk(ovf_o == m_ovf, "R5 ovf", int'(ovf_o), int'(m_ovf));
      chk(irq_o == m_flag, "R6 irq", int'(irq_o), int'(m_flag));
      chk(rd_data_o == exp_rd(), "R2 readback", int'(rd_data_o), int'(exp_rd()));
      chk(wd_en_o == m_wde, "R8 wd_en", int'(wd_en_o), int'(m_wde));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = b;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [CW-1:0] held;
    logic [7:0]    d;
    void'($urandom(32'd20240611));
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_data_o == 8'h17, "R1 rd_data", int'(rd_data_o), 'h17);
    chk(cnt_o == '0, "R1 cnt", int'(cnt_o), 0);
    chk(!ovf_o && !irq_o, "R1 ovf/irq", int'({ovf_o, irq_o}), 0);
    chk(wd_en_o, "R1 wd_en", int'(wd_en_o), 1);
    cmp_on = 1;

    // R3 fastest tap, reach R5 wrap and R6 flag
    wr(8'h10);
    idle(300);
    chk(irq_o, "R6 flag after wrap", int'(irq_o), 1);

    // R7 clear zeroes counter and flag, bit 3 reads 0
    wr(8'h18);
    chk(cnt_o == '0 && !irq_o, "R7 clear", int'({irq_o, cnt_o}), 0);
    chk(rd_data_o == 8'h10, "R7 clear bit reads 0", int'(rd_data_o), 'h10);

    // R8 watchdog enable off
    wr(8'h00);
    chk(!wd_en_o, "R8 wd_en low", int'(wd_en_o), 0);

    // R4 oscillator source, constant level: divider ignored
    wr(8'h30);
    idle(6);
    held = cnt_o;
    idle(300);
    chk(cnt_o == held, "R4 no osc edge no count", int'(cnt_o), int'(held));
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); osc_i = ~osc_i;
      idle(4);
    end

    // random phase
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      wr_en_i = 1'b0;
      if ($urandom_range(399) == 0) begin
        d = 8'($urandom);
        if ($urandom_range(3) != 0) d[3] = 1'b0;
        wr_en_i = 1'b1; wr_data_i = d;
      end
      if ($urandom_range(5) == 0) osc_i = ~osc_i;
    end
    @(negedge clk); wr_en_i = 1'b0;

    // R3 slowest tap /1024 reaches a wrap
    wr(8'h1F);
    chk(!irq_o, "R7 clear before slow run", int'(irq_o), 0);
    idle(17500);
    chk(irq_o, "R3 /1024 wrap sets flag", int'(irq_o), 1);

    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule